// File: doc/BRIEF.md
# Section Overhead Transmit Byte Inserter

The block sits on the transmit byte stream of a SONET/SDH framer. Each cycle in which `in_vld` is high carries one byte. A slot code comes with that byte and says which section overhead byte, if any, belongs at that position. For the B1, E1, F1 and D1 to D3 positions, the block replaces the payload byte with the matching overhead value. Every other position passes through untouched. `frm_start` marks the first byte of each frame. The block keeps a running even parity per bit over the bytes it sends. At each frame boundary that parity is frozen, and it fills the B1 slot of the following frame.

The overhead values come from register-style controls and two serial inputs. The orderwire serial input feeds E1 when it is enabled. F1 comes from a user register. D1 to D3 come from a two-bit enable/source code, which selects zeros, a serial data-channel input or a parallel bus port. B1 can be forced to zero. A single-shot error request XORs a programmable pattern into one B1 byte. Each serial input is shifted MSB first into a shift register. A byte strobe copies the shift register into a holding register, which the matching slot then reads.

Top module: `soh_tx_inserter`

## Requirements
- R1: `out_vld` equals `in_vld` of the previous cycle. `out_byte` is the byte chosen for the cycle in which `in_vld` was high, one clock later.
- R2: Slot code 0 (payload) and code 7 (reserved) pass `pay_in` to `out_byte` unchanged.
- R3: At slot code 1 (B1), with no error pending and B1 not disabled, the output is the bitwise XOR of every byte sent from the previous `frm_start` byte up to the byte just before the latest `frm_start` byte. For the first frame, this covers all bytes sent since reset.
- R4: While `bip_off` is high, the B1 value before error insertion is 00h.
- R5: An `err_req` pulse makes the next B1 byte equal the B1 value before error insertion XOR `err_pat`. This includes a B1 byte in the same cycle as the pulse. Only one B1 byte is affected, and the request then clears itself.
- R6: At slot code 2 (E1), the output is 00h while `ow_en` is low.
- R7: While `ow_en` is high, E1 carries the orderwire holding byte. `ow_bit` is shifted in MSB first on cycles where `ow_bit_vld` is high. `ow_byte_strb` loads the holding byte with the last 8 bits received, counting the bit of the strobe cycle. The new value is used from the next cycle on.
- R8: At slot code 3 (F1), the output equals `user_f1`.
- R9: At slot codes 4, 5 and 6 (D1, D2, D3), the code `{dcc_en,dcc_src}` picks the output. Codes 00 and 01 give 00h. Code 10 gives the data-channel holding byte, which follows the same shift and strobe rule as R7 using `dcc_bit`, `dcc_bit_vld` and `dcc_byte_strb`. Code 11 gives `sib_dcc`.
- R10: After reset, `out_vld` is 0, `out_byte` is 00h, both holding bytes are 00h, the parity is 00h and no error is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Input byte valid |
| frm_start | input | 1 | First byte of a frame |
| slot_code | input | 3 | Position code: 0 payload, 1 B1, 2 E1, 3 F1, 4 D1, 5 D2, 6 D3, 7 reserved |
| pay_in | input | 8 | Incoming stream byte |
| user_f1 | input | 8 | User channel register |
| ow_en | input | 1 | Orderwire enable for E1 |
| ow_bit | input | 1 | Orderwire serial data |
| ow_bit_vld | input | 1 | Orderwire bit strobe |
| ow_byte_strb | input | 1 | Orderwire byte capture strobe |
| dcc_en | input | 1 | Data channel enable |
| dcc_src | input | 1 | Data channel source: 0 serial, 1 bus port |
| dcc_bit | input | 1 | Data channel serial data |
| dcc_bit_vld | input | 1 | Data channel bit strobe |
| dcc_byte_strb | input | 1 | Data channel byte capture strobe |
| sib_dcc | input | 8 | Data channel byte from the bus port |
| bip_off | input | 1 | Force B1 to 00h before error insertion |
| err_req | input | 1 | Single-shot B1 error request |
| err_pat | input | 8 | B1 error pattern |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Outgoing stream byte |

## Verification
Every output byte is due exactly one clock after its input cycle. The bench therefore drives a byte on a falling edge, waits for the next rising edge, and compares one time unit later. A strobe changes a holding byte only from the next cycle on. A frame start freezes the parity for B1 slots in later cycles, and an error request acts on the first B1 slot at or after it. The bench model steps in the same order: it first computes the expected byte from the state before the cycle, and only then applies that cycle's shifts, strobes, parity update and request.

// File: rtl/soh_pkg.sv
package soh_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SL_PAY = 3'd0,
    SL_B1  = 3'd1,
    SL_E1  = 3'd2,
    SL_F1  = 3'd3,
    SL_D1  = 3'd4,
    SL_D2  = 3'd5,
    SL_D3  = 3'd6,
    SL_RSV = 3'd7
  } slot_e;

  // B1 value: parity or zero, then optional pattern XOR
  function automatic logic [BYTE_W-1:0] b1_value(
    input logic [BYTE_W-1:0] parity,
    input logic              force_zero,
    input logic              corrupt,
    input logic [BYTE_W-1:0] pattern);
    logic [BYTE_W-1:0] base;
    base = force_zero ? '0 : parity;
    return corrupt ? (base ^ pattern) : base;
  endfunction

  // data channel choice from {enable, source}
  function automatic logic [BYTE_W-1:0] dcc_value(
    input logic [1:0]        mode,
    input logic [BYTE_W-1:0] serial_byte,
    input logic [BYTE_W-1:0] bus_byte);
    case (mode)
      2'b10:   return serial_byte;
      2'b11:   return bus_byte;
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/soh_ser_capture.sv
module soh_ser_capture #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_in,
  input  logic         bit_vld,
  input  logic         byte_strb,
  output logic [W-1:0] hold
);
  logic [W-1:0] sr;
  logic [W-1:0] sr_nxt;

  assign sr_nxt = bit_vld ? {sr[W-2:0], bit_in} : sr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr   <= '0;
      hold <= '0;
    end else begin
      sr <= sr_nxt;
      if (byte_strb) hold <= sr_nxt;
    end
  end
endmodule

// File: rtl/soh_bip_acc.sv
module soh_bip_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld,
  input  logic         frm_start,
  input  logic [W-1:0] byte_in,
  output logic [W-1:0] bip_prev
);
  logic [W-1:0] acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc      <= '0;
      bip_prev <= '0;
    end else if (vld) begin
      if (frm_start) begin
        bip_prev <= acc;
        acc      <= byte_in;
      end else begin
        acc <= acc ^ byte_in;
      end
    end
  end
endmodule

// File: rtl/soh_tx_inserter.sv
module soh_tx_inserter
  import soh_pkg::*;
#(
  parameter int W = BYTE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic         frm_start,
  input  logic [2:0]   slot_code,
  input  logic [W-1:0] pay_in,
  input  logic [W-1:0] user_f1,
  input  logic         ow_en,
  input  logic         ow_bit,
  input  logic         ow_bit_vld,
  input  logic         ow_byte_strb,
  input  logic         dcc_en,
  input  logic         dcc_src,
  input  logic         dcc_bit,
  input  logic         dcc_bit_vld,
  input  logic         dcc_byte_strb,
  input  logic [W-1:0] sib_dcc,
  input  logic         bip_off,
  input  logic         err_req,
  input  logic [W-1:0] err_pat,
  output logic         out_vld,
  output logic [W-1:0] out_byte
);
  slot_e        slot;
  logic [W-1:0] ow_hold;
  logic [W-1:0] dcc_hold;
  logic [W-1:0] bip_prev;
  logic [W-1:0] nxt_byte;
  logic         err_pend;
  logic         err_live;
  logic         b1_slot;
  logic         err_fire;

  assign slot     = slot_e'(slot_code);
  assign b1_slot  = in_vld && (slot == SL_B1);
  assign err_live = err_pend | err_req;
  assign err_fire = b1_slot && err_live;

  soh_ser_capture #(.W(W)) u_ow_cap (
    .clk(clk), .rst_n(rst_n), .bit_in(ow_bit), .bit_vld(ow_bit_vld),
    .byte_strb(ow_byte_strb), .hold(ow_hold));

  soh_ser_capture #(.W(W)) u_dcc_cap (
    .clk(clk), .rst_n(rst_n), .bit_in(dcc_bit), .bit_vld(dcc_bit_vld),
    .byte_strb(dcc_byte_strb), .hold(dcc_hold));

  soh_bip_acc #(.W(W)) u_bip (
    .clk(clk), .rst_n(rst_n), .vld(in_vld), .frm_start(frm_start),
    .byte_in(nxt_byte), .bip_prev(bip_prev));

  always_comb begin
    case (slot)
      SL_B1:               nxt_byte = b1_value(bip_prev, bip_off, err_live, err_pat);
      SL_E1:               nxt_byte = ow_en ? ow_hold : '0;
      SL_F1:               nxt_byte = user_f1;
      SL_D1, SL_D2, SL_D3: nxt_byte = dcc_value({dcc_en, dcc_src}, dcc_hold, sib_dcc);
      default:             nxt_byte = pay_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_byte <= '0;
      err_pend <= 1'b0;
    end else begin
      out_vld <= in_vld;
      if (in_vld) out_byte <= nxt_byte;
      if (b1_slot)      err_pend <= 1'b0;
      else if (err_req) err_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/soh_tx_inserter_chk.sv
module soh_tx_inserter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_vld,
  input logic [2:0]   slot_code,
  input logic [W-1:0] pay_in,
  input logic [W-1:0] user_f1,
  input logic         ow_en,
  input logic         dcc_en,
  input logic [W-1:0] sib_dcc,
  input logic         dcc_src,
  input logic         bip_off,
  input logic         err_req,
  input logic         err_pend,
  input logic         err_fire,
  input logic [W-1:0] bip_prev,
  input logic         out_vld,
  input logic [W-1:0] out_byte
);
  assert_vld_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_vld_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_payload_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && (slot_code == 3'd0 || slot_code == 3'd7)) |=> out_byte == $past(pay_in));
  assert_b1_parity_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && slot_code == 3'd1 && !bip_off && !err_pend && !err_req)
      |=> out_byte == $past(bip_prev));
  assert_b1_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && slot_code == 3'd1 && bip_off && !err_pend && !err_req) |=> out_byte == '0);
  assert_err_oneshot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_fire |=> !err_pend);
  assert_err_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_req && !err_fire) |=> err_pend);
  assert_e1_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && slot_code == 3'd2 && !ow_en) |=> out_byte == '0);
  assert_f1_user_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && slot_code == 3'd3) |=> out_byte == $past(user_f1));
  assert_dcc_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && slot_code >= 3'd4 && slot_code <= 3'd6 && !dcc_en) |=> out_byte == '0);
  assert_dcc_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && slot_code >= 3'd4 && slot_code <= 3'd6 && dcc_en && dcc_src)
      |=> out_byte == $past(sib_dcc));
endmodule

bind soh_tx_inserter soh_tx_inserter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .slot_code(slot_code),
  .pay_in(pay_in), .user_f1(user_f1), .ow_en(ow_en), .dcc_en(dcc_en),
  .sib_dcc(sib_dcc), .dcc_src(dcc_src), .bip_off(bip_off), .err_req(err_req),
  .err_pend(err_pend), .err_fire(err_fire), .bip_prev(bip_prev),
  .out_vld(out_vld), .out_byte(out_byte));

// File: tb/soh_tx_inserter_tb.sv
module soh_tx_inserter_tb;
  localparam int FLEN = 24;
  localparam int NFRM = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 0, frm_start = 0;
  logic [2:0] slot_code = 0;
  logic [7:0] pay_in = 0, user_f1 = 0, sib_dcc = 0, err_pat = 0;
  logic ow_en = 0, ow_bit = 0, ow_bit_vld = 0, ow_byte_strb = 0;
  logic dcc_en = 0, dcc_src = 0, dcc_bit = 0, dcc_bit_vld = 0, dcc_byte_strb = 0;
  logic bip_off = 0, err_req = 0;
  logic out_vld;
  logic [7:0] out_byte;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // bench model state
  logic [7:0] m_acc = 0, m_bip = 0, m_owsr = 0, m_owh = 0, m_dsr = 0, m_dh = 0;
  logic m_pend = 0;

  always #5 clk = ~clk;

  soh_tx_inserter u_dut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .frm_start(frm_start),
    .slot_code(slot_code), .pay_in(pay_in), .user_f1(user_f1), .ow_en(ow_en),
    .ow_bit(ow_bit), .ow_bit_vld(ow_bit_vld), .ow_byte_strb(ow_byte_strb),
    .dcc_en(dcc_en), .dcc_src(dcc_src), .dcc_bit(dcc_bit),
    .dcc_bit_vld(dcc_bit_vld), .dcc_byte_strb(dcc_byte_strb), .sib_dcc(sib_dcc),
    .bip_off(bip_off), .err_req(err_req), .err_pat(err_pat),
    .out_vld(out_vld), .out_byte(out_byte));

  function automatic logic [7:0] tb_b1(logic [7:0] par, logic zero, logic bad, logic [7:0] pat);
    logic [7:0] v;
    v = zero ? 8'h00 : par;
    if (bad) v = v ^ pat;
    return v;
  endfunction

  function automatic logic [7:0] tb_shift(logic [7:0] sr, logic b);
    return {sr[6:0], b};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // one cycle: expected from old model state, then model update
  task automatic step(logic vld, logic st, logic [2:0] sc);
    logic [7:0] exp;
    string tag;
    @(negedge clk);
    in_vld = vld; frm_start = st; slot_code = sc;
    pay_in = 8'($urandom); sib_dcc = 8'($urandom);
    ow_bit = 1'($urandom); ow_bit_vld = 1'($urandom);
    dcc_bit = 1'($urandom); dcc_bit_vld = 1'($urandom);
    exp = pay_in; tag = "R2";
    case (sc)
      3'd1: begin
        exp = tb_b1(m_bip, bip_off, m_pend | err_req, err_pat);
        tag = (m_pend | err_req) ? "R5" : (bip_off ? "R4" : "R3");
      end
      3'd2: begin exp = ow_en ? m_owh : 8'h00; tag = ow_en ? "R7" : "R6"; end
      3'd3: begin exp = user_f1; tag = "R8"; end
      3'd4, 3'd5, 3'd6: begin
        tag = "R9";
        exp = !dcc_en ? 8'h00 : (dcc_src ? sib_dcc : m_dh);
      end
      default: ;
    endcase
    // model update
    if (ow_bit_vld) m_owsr = tb_shift(m_owsr, ow_bit);
    if (ow_byte_strb) m_owh = m_owsr;
    if (dcc_bit_vld) m_dsr = tb_shift(m_dsr, dcc_bit);
    if (dcc_byte_strb) m_dh = m_dsr;
    if (vld) begin
      if (st) begin m_bip = m_acc; m_acc = exp; end
      else m_acc = m_acc ^ exp;
    end
    if (vld && sc == 3'd1) m_pend = 1'b0;
    else if (err_req) m_pend = 1'b1;
    @(posedge clk); #1;
    chk("R1", {7'd0, out_vld}, {7'd0, vld});
    if (vld) chk(tag, out_byte, exp);
    err_req = 1'b0;
  endtask

  function automatic logic [2:0] slot_at(int b);
    case (b)
      3: return 3'd1;
      5: return 3'd2;
      7: return 3'd3;
      9: return 3'd4;
      10: return 3'd5;
      11: return 3'd6;
      15: return 3'd7;
      default: return 3'd0;
    endcase
  endfunction

  initial begin
    void'($urandom(32'h5a17));
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", out_byte, 8'h00);
    chk("R10", {7'd0, out_vld}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    for (int f = 0; f < NFRM; f++) begin
      int err_at;
      err_at = -1;
      user_f1 = 8'($urandom);
      err_pat = 8'($urandom) | 8'h01;
      ow_en = 1'($urandom); bip_off = ($urandom % 4) == 0;
      {dcc_en, dcc_src} = 2'($urandom);
      if ($urandom % 5 == 0) err_at = int'($urandom % FLEN);
      case (f)
        0: begin ow_en = 0; bip_off = 0; {dcc_en, dcc_src} = 2'b00; end
        1: begin bip_off = 1; {dcc_en, dcc_src} = 2'b01; end        // R4
        2: begin bip_off = 0; err_pat = 8'hA5; err_at = 1; end      // R5 early request
        3: begin bip_off = 0; err_at = -1; {dcc_en, dcc_src} = 2'b10; end // R5 cleared
        4: begin bip_off = 1; err_pat = 8'h3C; err_at = 3; end      // R5 same cycle as B1
        5: begin ow_en = 1; {dcc_en, dcc_src} = 2'b11; err_at = -1; end // R7 R9
        default: ;
      endcase
      for (int b = 0; b < FLEN; b++) begin
        if ($urandom % 10 == 0) step(1'b0, 1'b0, 3'd1); // idle cycle, slot ignored
        ow_byte_strb = (b == 2);
        dcc_byte_strb = (b == 8) || (b == 9) || (b == 10);
        if (b == err_at) err_req = 1'b1;
        step(1'b1, b == 0, slot_at(b));
        ow_byte_strb = 0; dcc_byte_strb = 0;
      end
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule